// File: doc/BRIEF.md
# Open-Loop Six-Step Spin-Up Sequencer

This block brings a three-phase brushless motor from standstill to a speed at which a back-EMF controller can take over. It uses no feedback. After a start pulse it steps through the six commutation states in a fixed rotation. Each state is held for a dwell of several chop frames. A frame drives the state's phase pattern for a short on interval, then pulls every phase low for a longer braking interval. The dwell begins long and is reduced by one frame after every complete six-state cycle, so the commutation rate rises steadily.

When the sweep reaches its final dwell, the block floats all three phases and emits a one-cycle done pulse. This pulse is the handover to the run-time controller. The phase commands are 2-bit codes per phase, intended for a gate driver stage that lies outside this block. Initial dwell, final dwell, on ticks and off ticks are parameters.

Top module: `sixstep_start_seq`

## Requirements
- R1: While reset is asserted and after it is released, all three phase commands read 00 (float) and `done` is low.
- R2: A `start` pulse sampled while idle makes the outputs show state 1 (U high, V low, W float) in the very next cycle.
- R3: Phase codes are 00 float, 01 low and 10 high; 11 never appears. States run 1→2→3→4→5→6 and then wrap to 1. The patterns are: 1: U=10 V=01 W=00; 2: U=10 V=00 W=01; 3: U=00 V=10 W=01; 4: U=01 V=10 W=00; 5: U=01 V=00 W=10; 6: U=00 V=01 W=10.
- R4: Each frame is ON_TICKS cycles of the state pattern, followed by OFF_TICKS cycles in which every phase reads 01 (low). The state pattern then returns.
- R5: Each state is held for exactly the current dwell in frames. The first cycle uses a dwell of START_FRAMES.
- R6: After each complete six-state cycle, the dwell decreases by one.
- R7: The six-state cycle run at dwell END_FRAMES is the last one. The dwell would next become END_FRAMES-1, so the cycle after its final braking interval shows all phases at 00 and `done` high. `done` is high for that one cycle only.
- R8: A `start` pulse arriving while a sweep is in progress has no effect on the output sequence.
- R9: After handover, the outputs stay at 00 until a new `start` arrives. That new start restarts the sweep from state 1 with dwell START_FRAMES.
- R10: Asserting reset mid-sweep floats all phases immediately. A later start runs a full, clean sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| u_cmd | output | 2 | Phase U command (00 float, 01 low, 10 high) |
| v_cmd | output | 2 | Phase V command |
| w_cmd | output | 2 | Phase W command |
| done | output | 1 | One-cycle handover pulse at the end of the sweep |

## Verification
Two parameter sets are exercised. A small multi-cycle sweep checks that the dwell decrement, the state rotation and the on/off split stay correct across every cycle. A degenerate set with one-tick intervals, where the initial dwell equals the final dwell, exposes off-by-one errors in the end test and the tick counter. Random idle gaps and random stray start pulses during a sweep separate true start gating from sequences that merely happen to match. A reset dropped at a random point mid-sweep, followed by a fresh sweep, shows that no counter state survives the reset.

// File: rtl/sixstep_start_seq.sv
module sixstep_start_seq #(
  parameter int START_FRAMES = 100,
  parameter int END_FRAMES   = 20,
  parameter int ON_TICKS     = 35,
  parameter int OFF_TICKS    = 170
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic [1:0] u_cmd,
  output logic [1:0] v_cmd,
  output logic [1:0] w_cmd,
  output logic       done
);
  localparam int TMAX = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int TW = $clog2(TMAX + 1);
  localparam int FW = $clog2(START_FRAMES + 1);
  localparam logic [TW-1:0] ON_LAST  = TW'(ON_TICKS - 1);
  localparam logic [TW-1:0] OFF_LAST = TW'(OFF_TICKS - 1);
  localparam logic [FW-1:0] DW_INIT  = FW'(START_FRAMES);
  localparam logic [FW-1:0] DW_FINAL = FW'(END_FRAMES);

  logic          run, on_ph;
  logic [2:0]    step;
  logic [TW-1:0] tick;
  logic [FW-1:0] frm, dwell;
  logic [5:0]    drv;

  wire tick_last = on_ph ? (tick == ON_LAST) : (tick == OFF_LAST);
  wire frame_end = run && !on_ph && (tick == OFF_LAST);
  wire step_end  = frame_end && (frm == dwell - 1'b1);
  wire cycle_end = step_end && (step == 3'd5);
  wire sweep_end = cycle_end && (dwell == DW_FINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      on_ph <= 1'b1;
      step  <= '0;
      tick  <= '0;
      frm   <= '0;
      dwell <= DW_INIT;
      done  <= 1'b0;
    end else begin
      done <= sweep_end;
      if (!run) begin
        if (start) begin
          run   <= 1'b1;
          on_ph <= 1'b1;
          step  <= '0;
          tick  <= '0;
          frm   <= '0;
          dwell <= DW_INIT;
        end
      end else begin
        tick <= tick_last ? '0 : tick + 1'b1;
        if (tick_last) on_ph <= !on_ph;
        if (frame_end) frm <= step_end ? '0 : frm + 1'b1;
        if (step_end) step <= (step == 3'd5) ? 3'd0 : step + 3'd1;
        if (cycle_end) dwell <= dwell - 1'b1;
        if (sweep_end) run <= 1'b0;
      end
    end
  end

  always_comb begin
    case (step)
      3'd0:    drv = 6'b10_01_00;
      3'd1:    drv = 6'b10_00_01;
      3'd2:    drv = 6'b00_10_01;
      3'd3:    drv = 6'b01_10_00;
      3'd4:    drv = 6'b01_00_10;
      3'd5:    drv = 6'b00_01_10;
      default: drv = 6'b00_00_00;
    endcase
  end

  assign {u_cmd, v_cmd, w_cmd} = !run ? 6'b00_00_00 : (on_ph ? drv : 6'b01_01_01);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({u_cmd, v_cmd, w_cmd} == 6'b0));
  // R3
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_cmd != 2'b11) && (v_cmd != 2'b11) && (w_cmd != 2'b11));
  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run) |=> ({u_cmd, v_cmd, w_cmd} == 6'b10_01_00));
  // R8
  keep_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sweep_end) |=> run);
endmodule

// File: tb/test_sixstep_start_seq.sv
`timescale 1ns/1ps
module test_sixstep_start_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_a = 1'b0, start_b = 1'b0;
  logic sel = 1'b0;
  logic [1:0] ua, va, wa, ub, vb, wb;
  logic done_a, done_b;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  sixstep_start_seq #(.START_FRAMES(5), .END_FRAMES(3), .ON_TICKS(2), .OFF_TICKS(3))
    i_sixstep_start_seq (.clk(clk), .rst_n(rst_n), .start(start_a),
      .u_cmd(ua), .v_cmd(va), .w_cmd(wa), .done(done_a));

  sixstep_start_seq #(.START_FRAMES(2), .END_FRAMES(2), .ON_TICKS(1), .OFF_TICKS(1))
    i_sixstep_start_seq_min (.clk(clk), .rst_n(rst_n), .start(start_b),
      .u_cmd(ub), .v_cmd(vb), .w_cmd(wb), .done(done_b));

  wire [5:0] act_cmd  = sel ? {ub, vb, wb} : {ua, va, wa};
  wire       act_done = sel ? done_b : done_a;

  localparam logic [5:0] FLOAT = 6'b00_00_00;
  localparam logic [5:0] LOW   = 6'b01_01_01;

  function automatic logic [5:0] pat(input int s);
    case (s)
      0: return 6'b10_01_00;
      1: return 6'b10_00_01;
      2: return 6'b00_10_01;
      3: return 6'b01_10_00;
      4: return 6'b01_00_10;
      default: return 6'b00_01_10;
    endcase
  endfunction

  task automatic chk(input logic [5:0] exp_cmd, input logic exp_done, input string tag);
    n_cmp++;
    if (act_cmd !== exp_cmd || act_done !== exp_done) begin
      n_bad++;
      $display("FAIL %s: got cmd=%b done=%b, expected cmd=%b done=%b",
               tag, act_cmd, act_done, exp_cmd, exp_done);
    end
  endtask

  task automatic drive_start(input logic v);
    if (sel) start_b = v; else start_a = v;
  endtask

  task automatic tick_chk(input logic [5:0] e, input string tag, input bit inject);
    chk(e, 1'b0, tag);
    // R8: stray start pulses during a sweep
    drive_start(inject && ($urandom_range(0, 15) == 0));
    @(negedge clk);
  endtask

  task automatic run_seq(input int sf, input int ef, input int ont, input int offt, input bit inject);
    @(negedge clk);
    drive_start(1'b1);
    @(negedge clk);
    drive_start(1'b0);
    for (int d = sf; d >= ef; d--)
      for (int s = 0; s < 6; s++)
        for (int f = 0; f < d; f++) begin
          for (int t = 0; t < ont; t++)
            tick_chk(pat(s),
              (d == sf && s == 0 && f == 0) ? "R2" : (d < sf) ? "R6" : (f > 0) ? "R5" : "R3",
              inject);
          for (int t = 0; t < offt; t++) tick_chk(LOW, "R4", inject);
        end
    drive_start(1'b0);
    chk(FLOAT, 1'b1, "R7");
    @(negedge clk);
    chk(FLOAT, 1'b0, "R7");
  endtask

  task automatic idle_gap(input string tag);
    int n = $urandom_range(1, 8);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(FLOAT, 1'b0, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got no completion, expected finish within 200000 cycles");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(FLOAT, 1'b0, "R1");
    rst_n = 1'b1;
    idle_gap("R1");
    run_seq(5, 3, 2, 3, 1'b0);
    idle_gap("R9");
    run_seq(5, 3, 2, 3, 1'b1);       // R8 with restart per R9
    idle_gap("R9");
    sel = 1'b1;
    run_seq(2, 2, 1, 1, 1'b1);
    idle_gap("R9");
    run_seq(2, 2, 1, 1, 1'b0);
    sel = 1'b0;
    // R10: reset dropped mid-sweep
    @(negedge clk);
    drive_start(1'b1);
    @(negedge clk);
    drive_start(1'b0);
    repeat ($urandom_range(4, 60)) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(FLOAT, 1'b0, "R10");
    @(negedge clk);
    chk(FLOAT, 1'b0, "R10");
    rst_n = 1'b1;
    idle_gap("R10");
    run_seq(5, 3, 2, 3, 1'b1);
    idle_gap("R10");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule